// File: doc/BRIEF.md
# Dual-Axis Counter Host Register Front End

This block connects an 8-bit asynchronous host bus to the register set of a two-axis (X/Y) counter. The host drives active-low chip select, read and write strobes, a control/data select and an axis select. The block moves these pins into the system clock domain and detects the trailing edge of each strobe. On that edge it decodes the byte the host wrote. It then updates per-axis configuration registers, loads a 24-bit preset register one byte at a time, or issues single-cycle command strobes to the counter cores. Those cores are outside this block.

Reads are combinational from the pins. With control/data select low, a read returns one byte of the 24-bit output-latch value that the counter core supplies. With it high, a read returns the core's status byte. A two-bit byte pointer for each axis chooses which byte of a preset write or latch read is accessed. The pointer moves on after each data transfer, so a 24-bit value crosses the bus as three transfers, lowest byte first.

The bus is a plain strobe interface with no valid/ready handshake and no back-pressure. The host must keep each strobe low for at least three clock periods. It must hold data, select and chip select for at least three clock periods after the trailing edge, and leave at least three idle clock periods between transfers.

Top module: `host_regif`

## Requirements
- R1: After reset, the preset, mode, I/O-configuration and index-configuration registers of both axes are zero, both byte pointers are 0, all command strobes are low, and `dout_oe` is low.
- R2: A write with `cd_i`=1 and `din[7]`=0 goes to the axis given by `axis_i` (0 = X, index 0; 1 = Y, index 1). `din[6:5]` picks the target: 00 command, 01 mode, 10 I/O configuration, 11 index configuration. A configuration target stores `din[4:0]`, and the other axis is left unchanged.
- R3: A control write with `din[7]`=1 goes to both axes, whatever the value of `axis_i`.
- R4: In a command byte, `din[2:1]` set to 01 pulses `rst_cnt_o`, set to 10 pulses `rst_flg_o`, and set to 11 pulses `rst_err_o`, for each addressed axis. A value of 00 pulses nothing.
- R5: In a command byte, `din[4:3]` set to 01 pulses `ld_cnt_o` (preset to counter), set to 10 pulses `ld_ol_o` (counter to output latch), and set to 11 pulses `ld_psc_o` (low preset byte to prescaler). A value of 00 pulses nothing.
- R6: A command byte with `din[0]`=1 sets the byte pointer of each addressed axis to 0.
- R7: A write with `cd_i`=0 stores `din` into the preset byte selected by that axis's pointer (0 = bits 7:0, 1 = 15:8, 2 = 23:16). The pointer then advances and wraps from 2 back to 0.
- R8: A read with `cd_i`=0 returns the output-latch byte of the selected axis at its pointer (same byte numbering as R7). The trailing edge of the read advances that pointer, with the same wrap.
- R9: A read with `cd_i`=1 returns `stat_i` of the selected axis and leaves the byte pointers unchanged.
- R10: `dout_oe` is high only while `cs_n` and `rd_n` are both low. `dout` is zero whenever `dout_oe` is low.
- R11: A strobe given while `cs_n` is high changes no register, pointer or strobe.
- R12: A write takes effect on the third rising clock edge after `wr_n` rises. Command strobes last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_i | input | 1 | 1 = control/status, 0 = preset/latch data |
| axis_i | input | 1 | Axis select, 0 = X, 1 = Y |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Read data drive enable |
| stat_i | input | 2x8 | Status byte per axis, from the counter cores |
| ol_i | input | 2x24 | Output-latch value per axis |
| preset_o | output | 2x24 | Preset register per axis |
| mode_o | output | 2x5 | Mode register per axis |
| ioc_o | output | 2x5 | I/O configuration per axis |
| idx_o | output | 2x5 | Index configuration per axis |
| rst_cnt_o | output | 2 | Reset-counter strobe per axis |
| rst_flg_o | output | 2 | Reset toggles/sign/index strobe per axis |
| rst_err_o | output | 2 | Reset error flag strobe per axis |
| ld_cnt_o | output | 2 | Preset-to-counter strobe per axis |
| ld_ol_o | output | 2 | Counter-to-latch strobe per axis |
| ld_psc_o | output | 2 | Preset low byte to prescaler strobe per axis |

## Verification
Register updates and command strobes appear on the third rising edge after a strobe's trailing edge: two synchronizer stages, then the register. Read data and `dout_oe` follow the pins with no clock delay. The bench holds each write or read for several cycles after the trailing edge before it compares registers and strobe counts. A dedicated test samples one register two edges after the trailing edge (old value expected) and again three edges after it (new value expected). Read data is sampled at a falling clock edge while the read strobe is still low.

// File: rtl/hrif_pkg.sv
package hrif_pkg;
  localparam int NAX = 2;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'b00,
    SEL_MODE = 2'b01,
    SEL_IOC  = 2'b10,
    SEL_IDX  = 2'b11
  } ctl_sel_e;

  typedef struct packed {
    logic rst_cnt;
    logic rst_flg;
    logic rst_err;
    logic ld_cnt;
    logic ld_ol;
    logic ld_psc;
  } cmd_strb_t;
endpackage

// File: rtl/hrif_sync.sv
module hrif_sync #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             cd,
  input  logic             axis,
  input  logic [BUS_W-1:0] din,
  output logic             wr_done,
  output logic             rd_done,
  output logic             cd_q,
  output logic             axis_q,
  output logic [BUS_W-1:0] din_q
);
  localparam int PW = BUS_W + 5;
  localparam logic [PW-1:0] IDLE = {3'b111, {(BUS_W+2){1'b0}}};

  logic [PW-1:0] s1, s2, s3;

  // Two stages move the pins into this clock domain; a third stage holds
  // the bus as it was just before the strobe rose.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
      s3 <= IDLE;
    end else begin
      s1 <= {cs_n, rd_n, wr_n, cd, axis, din};
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_comb begin
    wr_done = s2[PW-3] && !s3[PW-3] && !s3[PW-1];
    rd_done = s2[PW-2] && !s3[PW-2] && !s3[PW-1];
    cd_q    = s3[BUS_W+1];
    axis_q  = s3[BUS_W];
    din_q   = s3[BUS_W-1:0];
  end

  a_r12_wr_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  a_r12_rd_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);
endmodule

// File: rtl/hrif_decode.sv
module hrif_decode
  import hrif_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_done,
  input  logic                 cd,
  input  logic                 axis,
  input  logic [BUS_W-1:0]     din,
  output logic [NAX-1:0]       pr_we,
  output logic [NAX-1:0]       mode_we,
  output logic [NAX-1:0]       ioc_we,
  output logic [NAX-1:0]       idx_we,
  output logic [NAX-1:0]       bp_clr,
  output cmd_strb_t [NAX-1:0]  cmd_q
);
  logic [NAX-1:0] one_axis, ctl_tgt;
  ctl_sel_e       sel;
  logic           ctl_wr, cmd_wr;
  cmd_strb_t      cmd_next;

  always_comb begin
    one_axis = NAX'(1) << axis;
    ctl_tgt  = din[7] ? {NAX{1'b1}} : one_axis;   // bit 7 broadcasts
    sel      = ctl_sel_e'(din[6:5]);
    ctl_wr   = wr_done && cd;
    cmd_wr   = ctl_wr && (sel == SEL_CMD);
    pr_we    = (wr_done && !cd) ? one_axis : '0;
    mode_we  = (ctl_wr && sel == SEL_MODE) ? ctl_tgt : '0;
    ioc_we   = (ctl_wr && sel == SEL_IOC)  ? ctl_tgt : '0;
    idx_we   = (ctl_wr && sel == SEL_IDX)  ? ctl_tgt : '0;
    bp_clr   = (cmd_wr && din[0]) ? ctl_tgt : '0;
    cmd_next.rst_cnt = (din[2:1] == 2'b01);
    cmd_next.rst_flg = (din[2:1] == 2'b10);
    cmd_next.rst_err = (din[2:1] == 2'b11);
    cmd_next.ld_cnt  = (din[4:3] == 2'b01);
    cmd_next.ld_ol   = (din[4:3] == 2'b10);
    cmd_next.ld_psc  = (din[4:3] == 2'b11);
  end

  for (genvar a = 0; a < NAX; a++) begin : g_cmd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_q[a] <= '0;
      else        cmd_q[a] <= (cmd_wr && ctl_tgt[a]) ? cmd_next : '0;
    end

    a_r12_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_q[a]) |=> !(|cmd_q[a]));
    a_r4_strobe_from_write: assert property (@(posedge clk) disable iff (!rst_n)
      (|cmd_q[a]) |-> $past(wr_done && cd));
    a_r4_reset_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_q[a].rst_cnt, cmd_q[a].rst_flg, cmd_q[a].rst_err}));
    a_r5_load_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_q[a].ld_cnt, cmd_q[a].ld_ol, cmd_q[a].ld_psc}));
  end
endmodule

// File: rtl/hrif_axis.sv
module hrif_axis #(
  parameter int CNT_W = 24,
  parameter int CFG_W = 5,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pr_we,
  input  logic             mode_we,
  input  logic             ioc_we,
  input  logic             idx_we,
  input  logic             bp_clr,
  input  logic             rd_adv,
  input  logic [BUS_W-1:0] wdata,
  output logic [CNT_W-1:0] preset_q,
  output logic [CFG_W-1:0] mode_q,
  output logic [CFG_W-1:0] ioc_q,
  output logic [CFG_W-1:0] idx_q,
  output logic [(CNT_W/BUS_W > 1 ? $clog2(CNT_W/BUS_W) : 1)-1:0] bp_q
);
  localparam int NBYTE = CNT_W / BUS_W;
  localparam int BP_W  = NBYTE > 1 ? $clog2(NBYTE) : 1;

  logic [BP_W-1:0] bp_next;

  always_comb begin
    bp_next = (bp_q == BP_W'(NBYTE - 1)) ? '0 : bp_q + BP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
      mode_q   <= '0;
      ioc_q    <= '0;
      idx_q    <= '0;
      bp_q     <= '0;
    end else begin
      if (pr_we)   preset_q[bp_q*BUS_W +: BUS_W] <= wdata;
      if (mode_we) mode_q <= wdata[CFG_W-1:0];
      if (ioc_we)  ioc_q  <= wdata[CFG_W-1:0];
      if (idx_we)  idx_q  <= wdata[CFG_W-1:0];
      if (bp_clr)               bp_q <= '0;
      else if (pr_we || rd_adv) bp_q <= bp_next;
    end
  end

  a_r7_bp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q != $past(bp_q)) |-> (bp_q == '0 || bp_q == $past(bp_q) + BP_W'(1)));
  a_r7_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(preset_q) |-> $past(pr_we));
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(mode_we));
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ioc_q, idx_q}) |-> $past(ioc_we || idx_we));
endmodule

// File: rtl/host_regif.sv
module host_regif
  import hrif_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CFG_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         rd_n,
  input  logic                         wr_n,
  input  logic                         cd_i,
  input  logic                         axis_i,
  input  logic [7:0]                   din,
  output logic [7:0]                   dout,
  output logic                         dout_oe,
  input  logic [NAX-1:0][7:0]          stat_i,
  input  logic [NAX-1:0][CNT_W-1:0]    ol_i,
  output logic [NAX-1:0][CNT_W-1:0]    preset_o,
  output logic [NAX-1:0][CFG_W-1:0]    mode_o,
  output logic [NAX-1:0][CFG_W-1:0]    ioc_o,
  output logic [NAX-1:0][CFG_W-1:0]    idx_o,
  output logic [NAX-1:0]               rst_cnt_o,
  output logic [NAX-1:0]               rst_flg_o,
  output logic [NAX-1:0]               rst_err_o,
  output logic [NAX-1:0]               ld_cnt_o,
  output logic [NAX-1:0]               ld_ol_o,
  output logic [NAX-1:0]               ld_psc_o
);
  localparam int BUS_W = 8;
  localparam int NBYTE = CNT_W / BUS_W;
  localparam int BP_W  = NBYTE > 1 ? $clog2(NBYTE) : 1;

  logic             wr_done, rd_done, cd_q, axis_q;
  logic [BUS_W-1:0] din_q;
  logic [NAX-1:0]   pr_we, mode_we, ioc_we, idx_we, bp_clr;
  cmd_strb_t [NAX-1:0]       cmd_q;
  logic [NAX-1:0][BP_W-1:0]  bp_w;

  hrif_sync #(.BUS_W(BUS_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd(cd_i), .axis(axis_i), .din(din),
    .wr_done(wr_done), .rd_done(rd_done), .cd_q(cd_q), .axis_q(axis_q),
    .din_q(din_q)
  );

  hrif_decode #(.BUS_W(BUS_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .cd(cd_q), .axis(axis_q),
    .din(din_q), .pr_we(pr_we), .mode_we(mode_we), .ioc_we(ioc_we),
    .idx_we(idx_we), .bp_clr(bp_clr), .cmd_q(cmd_q)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    logic rd_adv;
    assign rd_adv = rd_done && !cd_q && (axis_q == a[0]);

    hrif_axis #(.CNT_W(CNT_W), .CFG_W(CFG_W), .BUS_W(BUS_W)) u_axis (
      .clk(clk), .rst_n(rst_n), .pr_we(pr_we[a]), .mode_we(mode_we[a]),
      .ioc_we(ioc_we[a]), .idx_we(idx_we[a]), .bp_clr(bp_clr[a]),
      .rd_adv(rd_adv), .wdata(din_q), .preset_q(preset_o[a]),
      .mode_q(mode_o[a]), .ioc_q(ioc_o[a]), .idx_q(idx_o[a]), .bp_q(bp_w[a])
    );

    assign rst_cnt_o[a] = cmd_q[a].rst_cnt;
    assign rst_flg_o[a] = cmd_q[a].rst_flg;
    assign rst_err_o[a] = cmd_q[a].rst_err;
    assign ld_cnt_o[a]  = cmd_q[a].ld_cnt;
    assign ld_ol_o[a]   = cmd_q[a].ld_ol;
    assign ld_psc_o[a]  = cmd_q[a].ld_psc;
  end

  // Read path is combinational from the pins: no clock delay on the data.
  logic [BUS_W-1:0] rd_byte;
  always_comb begin
    if (cd_i) rd_byte = stat_i[axis_i];
    else      rd_byte = ol_i[axis_i][bp_w[axis_i]*BUS_W +: BUS_W];
    dout_oe = !cs_n && !rd_n;
    dout    = dout_oe ? rd_byte : '0;
  end

  a_r11_no_write_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !wr_done && !rd_done);
endmodule

// File: tb/tb_host_regif.sv
module tb_host_regif;
  localparam int CNT_W = 24;
  localparam int CFG_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_i = 1'b0, axis_i = 1'b0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_oe;
  logic [1:0][7:0]       stat_i = '0;
  logic [1:0][CNT_W-1:0] ol_i = '0;
  logic [1:0][CNT_W-1:0] preset_o;
  logic [1:0][CFG_W-1:0] mode_o, ioc_o, idx_o;
  logic [1:0] rst_cnt_o, rst_flg_o, rst_err_o, ld_cnt_o, ld_ol_o, ld_psc_o;

  host_regif #(.CNT_W(CNT_W), .CFG_W(CFG_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .cd_i(cd_i), .axis_i(axis_i), .din(din), .dout(dout), .dout_oe(dout_oe),
    .stat_i(stat_i), .ol_i(ol_i), .preset_o(preset_o), .mode_o(mode_o),
    .ioc_o(ioc_o), .idx_o(idx_o), .rst_cnt_o(rst_cnt_o), .rst_flg_o(rst_flg_o),
    .rst_err_o(rst_err_o), .ld_cnt_o(ld_cnt_o), .ld_ol_o(ld_ol_o),
    .ld_psc_o(ld_psc_o)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;

  // bench model
  logic [1:0][CNT_W-1:0] m_preset = '0;
  logic [1:0][CFG_W-1:0] m_mode = '0, m_ioc = '0, m_idx = '0;
  int m_bp [2] = '{0, 0};
  int exp_cnt [2][6];
  int got_cnt [2][6];
  logic wide_pulse = 1'b0;
  logic [1:0][5:0] prev_strb = '0;

  always @(posedge clk) begin
    for (int a = 0; a < 2; a++) begin
      logic [5:0] s;
      s = {ld_psc_o[a], ld_ol_o[a], ld_cnt_o[a], rst_err_o[a], rst_flg_o[a], rst_cnt_o[a]};
      for (int k = 0; k < 6; k++) if (s[k]) got_cnt[a][k]++;
      if ((s & prev_strb[a]) != 0) wide_pulse = 1'b1;
      prev_strb[a] = s;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int bp_next(input int b);
    return (b == 2) ? 0 : b + 1;
  endfunction

  task automatic model_write(input logic cdv, input logic axv, input logic [7:0] d);
    if (!cdv) begin
      m_preset[axv][m_bp[axv]*8 +: 8] = d;
      m_bp[axv] = bp_next(m_bp[axv]);
    end else begin
      for (int a = 0; a < 2; a++) begin
        if (d[7] || a == int'(axv)) begin
          case (d[6:5])
            2'b00: begin
              if (d[0]) m_bp[a] = 0;
              if (d[2:1] != 2'b00) exp_cnt[a][int'(d[2:1]) - 1]++;
              if (d[4:3] != 2'b00) exp_cnt[a][3 + int'(d[4:3]) - 1]++;
            end
            2'b01: m_mode[a] = d[4:0];
            2'b10: m_ioc[a]  = d[4:0];
            default: m_idx[a] = d[4:0];
          endcase
        end
      end
    end
  endtask

  task automatic bus_wr(input logic cdv, input logic axv, input logic sel, input logic [7:0] d);
    @(negedge clk);
    cs_n = !sel; cd_i = cdv; axis_i = axv; din = d; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    if (sel) model_write(cdv, axv, d);
  endtask

  task automatic bus_rd(input string req, input logic cdv, input logic axv, input logic sel);
    logic [7:0] exp_d;
    @(negedge clk);
    cs_n = !sel; cd_i = cdv; axis_i = axv; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    if (!sel) exp_d = 8'h00;
    else if (cdv) exp_d = stat_i[axv];
    else exp_d = ol_i[axv][m_bp[axv]*8 +: 8];
    chk({req, " dout"}, {24'h0, dout}, {24'h0, exp_d});
    chk("R10 dout_oe during read", {31'h0, dout_oe}, {31'h0, sel});
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    if (sel && !cdv) m_bp[axv] = bp_next(m_bp[axv]);
  endtask

  task automatic check_state(input string tag);
    for (int a = 0; a < 2; a++) begin
      chk({tag, " R7 preset"}, {8'h0, preset_o[a]}, {8'h0, m_preset[a]});
      chk({tag, " R2 mode"}, {27'h0, mode_o[a]}, {27'h0, m_mode[a]});
      chk({tag, " R2 ioc"}, {27'h0, ioc_o[a]}, {27'h0, m_ioc[a]});
      chk({tag, " R2 idx"}, {27'h0, idx_o[a]}, {27'h0, m_idx[a]});
      for (int k = 0; k < 6; k++)
        chk({tag, " R4/R5 strobe count"}, got_cnt[a][k], exp_cnt[a][k]);
    end
    chk({tag, " R10 idle bus"}, {23'h0, dout_oe, dout}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int a = 0; a < 2; a++) for (int k = 0; k < 6; k++) begin
      exp_cnt[a][k] = 0; got_cnt[a][k] = 0;
    end
    void'($urandom(32'h5EED_1234));
    stat_i = {8'hA5, 8'h3C};
    ol_i   = {24'h778899, 24'h112233};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check_state("R1 reset");

    // R2 mode write to X only; Y untouched
    bus_wr(1'b1, 1'b0, 1'b1, 8'b0_01_10110);
    check_state("R2 mode X");
    // R3 broadcast I/O config with axis select pointing at X
    bus_wr(1'b1, 1'b0, 1'b1, 8'b1_10_01011);
    check_state("R3 broadcast ioc");
    bus_wr(1'b1, 1'b1, 1'b1, 8'b0_11_10001);
    check_state("R2 idx Y");

    // R4 and R5: every strobe kind
    bus_wr(1'b1, 1'b1, 1'b1, 8'b0_00_01_01_0);
    bus_wr(1'b1, 1'b0, 1'b1, 8'b0_00_10_10_0);
    bus_wr(1'b1, 1'b0, 1'b1, 8'b1_00_11_11_0);
    check_state("R4 R5 strobes");

    // R7 preset bytes low first, wrap on fourth byte
    bus_wr(1'b0, 1'b0, 1'b1, 8'h11);
    bus_wr(1'b0, 1'b0, 1'b1, 8'h22);
    bus_wr(1'b0, 1'b0, 1'b1, 8'h33);
    check_state("R7 three bytes");
    chk("R7 assembled", {8'h0, preset_o[0]}, 32'h332211);
    bus_wr(1'b0, 1'b0, 1'b1, 8'h44);
    chk("R7 wrap to byte 0", {8'h0, preset_o[0]}, 32'h332244);

    // R6 pointer reset, then R8 latch reads with wrap
    bus_wr(1'b1, 1'b0, 1'b1, 8'b0_00_00_00_1);
    bus_rd("R8 byte0", 1'b0, 1'b0, 1'b1);
    bus_rd("R8 byte1", 1'b0, 1'b0, 1'b1);
    bus_rd("R9 status keeps pointer", 1'b1, 1'b0, 1'b1);
    bus_rd("R8 byte2", 1'b0, 1'b0, 1'b1);
    bus_rd("R8 wrap", 1'b0, 1'b0, 1'b1);
    bus_rd("R9 status Y", 1'b1, 1'b1, 1'b1);
    bus_wr(1'b1, 1'b1, 1'b1, 8'b0_00_00_00_1);
    bus_rd("R6 Y pointer cleared", 1'b0, 1'b1, 1'b1);

    // R11 deselected write and read have no effect
    bus_wr(1'b1, 1'b0, 1'b0, 8'b1_01_11111);
    bus_wr(1'b0, 1'b1, 1'b0, 8'hEE);
    bus_wr(1'b1, 1'b0, 1'b0, 8'b1_00_11_11_1);
    bus_rd("R11 deselected read", 1'b0, 1'b0, 1'b0);
    check_state("R11 deselected");

    // R12 timing: new value on the third edge after wr_n rises
    @(negedge clk);
    cs_n = 1'b0; cd_i = 1'b1; axis_i = 1'b1; din = 8'b0_01_01010; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 not yet at edge 2", {27'h0, mode_o[1]}, {27'h0, m_mode[1]});
    @(negedge clk);
    chk("R12 updated at edge 3", {27'h0, mode_o[1]}, 32'h0A);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    m_mode[1] = 5'h0A;

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      logic sel, ax;
      op  = int'($urandom % 4);
      sel = ($urandom % 8) != 0;
      ax  = 1'($urandom);
      d   = 8'($urandom);
      stat_i = {8'($urandom), 8'($urandom)};
      ol_i   = {24'($urandom), 24'($urandom)};
      case (op)
        0: bus_wr(1'b1, ax, sel, d);
        1: bus_wr(1'b0, ax, sel, d);
        2: bus_rd("R8 random latch read", 1'b0, ax, sel);
        default: bus_rd("R9 random status read", 1'b1, ax, sel);
      endcase
      check_state("random");
    end

    chk("R12 strobes one cycle wide", {31'h0, wide_pulse}, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule